// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Deep Error-Tagged Buffer

This block receives asynchronous serial characters from a single input line. A free-running baud tick paces it at 16 ticks per bit, or at 8 ticks per bit when double speed is selected. Each frame has a start bit, 8 or 9 data bits sent least-significant first, an optional parity bit and a stop bit. The start bit is confirmed by a majority vote at its centre. Every later bit is taken as the majority of three samples around its own centre.

Finished characters go into a two-entry buffer, and each entry carries its own framing, parity and overrun flags. When the buffer is full, a third character can wait in a holding stage. A read strobe pops the head entry, and in the same clock any waiting character moves into the slot that was freed. In addressed multi-drop operation, frames marked as data are thrown away. A receive interrupt is raised while characters are pending and both enables are on.

Top module: `uart_rx_core`

## Requirements
- R1: `rx_ferr` is 1 for the head character exactly when the stop bit sampled for that character was 0.
- R2: The buffer holds two characters and returns them in arrival order. The data, `rx_bit8` and all flags shown belong to the head entry, stay unchanged until `rd_stb` pops it, and are 0 when the buffer is empty. `rd_stb` on an empty buffer has no effect.
- R3: `rx_ovr` is marked on the character waiting in the holding stage when a start bit is confirmed while both buffer entries and the holding stage are occupied. That incoming character is dropped if there is still no room when it completes, and `rx_ovr` shows once the waiting character reaches the head.
- R4: With `par_en`=1 a parity bit follows the data, and `rx_perr` records a mismatch. `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity, computed over all data bits including the ninth. With `par_en`=0 no parity bit is expected and `rx_perr` stays 0.
- R5: `dbl_speed`=1 uses 8 ticks per bit with votes on samples 3, 4 and 5. Otherwise there are 16 ticks per bit with votes on samples 7, 8 and 9.
- R6: With `mp_mode`=1 a frame is kept only if its marker bit is 1. The marker is data bit 8 in 9-bit mode and data bit 7 in 8-bit mode. Other frames never enter the buffer.
- R7: `rx_irq` is 1 only when `irq_en`=1, `gie`=1 and at least one character is buffered.
- R8: With `nine_bit`=1 the ninth data bit appears on `rx_bit8` together with its character. In 8-bit mode `rx_bit8` is 0.
- R9: A low level that is not confirmed as a start bit by the centre majority returns the receiver to idle and stores nothing. With `rx_en`=0 the receiver stays idle.
- R10: Data bits are assembled least-significant bit first onto `rx_data`.
- R11: When a pop frees a slot while a character waits in the holding stage, that character enters the buffer in the same clock.
- R12: After reset, `rx_avail`, `rx_irq`, `rx_data`, `rx_bit8` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | One-clock oversampling tick |
| rx_en | input | 1 | Receiver enable |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 0 even, 1 odd parity |
| nine_bit | input | 1 | 9 data bits per frame |
| dbl_speed | input | 1 | 8 ticks per bit instead of 16 |
| mp_mode | input | 1 | Keep address-marked frames only |
| irq_en | input | 1 | Receive interrupt enable |
| gie | input | 1 | Global interrupt enable |
| rd_stb | input | 1 | Pop the head character |
| rx_data | output | DATA_W | Head character, low 8 bits |
| rx_bit8 | output | 1 | Head character ninth bit |
| rx_ferr | output | 1 | Head framing error |
| rx_perr | output | 1 | Head parity error |
| rx_ovr | output | 1 | Overrun marked on head character |
| rx_avail | output | 1 | Buffer not empty |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The line passes through a two-flop synchronizer before sampling. A character is written into the buffer on the clock edge after the baud tick that holds the third sample of its stop bit. The bench therefore sends the complete stop bit plus two idle bit times before it looks at the outputs. A read strobe driven across a single rising edge changes the head on that edge, and the interrupt follows the buffer state and the enables combinationally in the same cycle. The bench drives every input and samples every output on falling edges, so each comparison falls half a clock after the edge that produced the value.

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int DATA_W = 8,
  parameter int OSR_N  = 16,
  parameter int OSR_D  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              baud_tick,
  input  logic              rx_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              nine_bit,
  input  logic              dbl_speed,
  input  logic              mp_mode,
  input  logic              irq_en,
  input  logic              gie,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit8,
  output logic              rx_ferr,
  output logic              rx_perr,
  output logic              rx_ovr,
  output logic              rx_avail,
  output logic              rx_irq
);
  localparam int DW1 = DATA_W + 1;
  localparam int EW  = DW1 + 3;
  localparam int FE  = DW1;
  localparam int PE  = DW1 + 1;
  localparam int OV  = DW1 + 2;
  localparam int TW  = $clog2(OSR_N);
  localparam int BW  = $clog2(DW1 + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t            st;
  logic [1:0]     rx_s;
  logic [TW-1:0]  tcnt;
  logic [BW-1:0]  bitn;
  logic [1:0]     vote;
  logic [DW1-1:0] shreg;
  logic           par_bit;
  logic [EW-1:0]  e0, e1, hold;
  logic [1:0]     cnt;
  logic           hv;
  logic           in_idle;

  wire rx = rx_s[1];
  wire [TW-1:0] mid   = dbl_speed ? TW'(OSR_D / 2) : TW'(OSR_N / 2);
  wire [TW-1:0] lastc = dbl_speed ? TW'(OSR_D - 1) : TW'(OSR_N - 1);
  wire [BW-1:0] nlast = nine_bit ? BW'(DW1 - 1) : BW'(DATA_W - 1);
  wire maj = (vote[1] & vote[0]) | (vote[1] & rx) | (vote[0] & rx);

  wire at_mid   = rx_en && baud_tick && st != S_IDLE && tcnt == mid + TW'(1);
  wire start_ok = at_mid && st == S_START && !maj;
  wire fin      = at_mid && st == S_STOP;

  wire [DW1-1:0] data9  = nine_bit ? shreg : {1'b0, shreg[DW1-1:1]};
  wire           marker = nine_bit ? shreg[DW1-1] : data9[DATA_W-1];
  wire           accept = !mp_mode || marker;
  wire           perr_n = par_en && (^data9 ^ par_bit ^ par_odd);
  wire [EW-1:0]  new_e  = {1'b0, perr_n, !maj, data9};

  wire pop     = rd_stb && cnt != 2'd0;
  wire ovr_evt = start_ok && cnt == 2'd2 && hv && !pop;

  assign in_idle = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_s <= 2'b11;
    else        rx_s <= {rx_s[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tcnt    <= '0;
      bitn    <= '0;
      vote    <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
    end else if (!rx_en) begin
      st <= S_IDLE;
    end else if (baud_tick) begin
      if (st == S_IDLE) begin
        if (!rx) begin
          st   <= S_START;
          tcnt <= TW'(1);
        end
      end else begin
        tcnt <= (tcnt == lastc) ? '0 : tcnt + TW'(1);
        if (tcnt == mid - TW'(1)) vote[1] <= rx;
        if (tcnt == mid)          vote[0] <= rx;
        if (tcnt == mid + TW'(1)) begin
          case (st)
            S_START: if (maj) st <= S_IDLE;
            S_DATA:  shreg <= {maj, shreg[DW1-1:1]};
            S_PAR:   par_bit <= maj;
            S_STOP:  st <= S_IDLE;
            default: ;
          endcase
        end
        if (tcnt == lastc) begin
          case (st)
            S_START: begin st <= S_DATA; bitn <= '0; end
            S_DATA: begin
              bitn <= bitn + BW'(1);
              if (bitn == nlast) st <= par_en ? S_PAR : S_STOP;
            end
            S_PAR:   st <= S_STOP;
            default: ;
          endcase
        end
      end
    end
  end

  logic [EW-1:0] n_e0, n_e1, n_hold;
  logic [1:0]    n_cnt;
  logic          n_hv;

  always_comb begin
    n_e0 = e0; n_e1 = e1; n_hold = hold; n_cnt = cnt; n_hv = hv;
    if (pop) begin
      n_e0  = e1;
      n_e1  = '0;
      n_cnt = cnt - 2'd1;
    end
    if (ovr_evt) n_hold[OV] = 1'b1;
    if (n_hv && n_cnt != 2'd2) begin
      if (n_cnt == 2'd0) n_e0 = n_hold;
      else               n_e1 = n_hold;
      n_cnt  = n_cnt + 2'd1;
      n_hv   = 1'b0;
      n_hold = '0;
    end
    if (fin && accept) begin
      if (n_cnt != 2'd2) begin
        if (n_cnt == 2'd0) n_e0 = new_e;
        else               n_e1 = new_e;
        n_cnt = n_cnt + 2'd1;
      end else if (!n_hv) begin
        n_hold = new_e;
        n_hv   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e0 <= '0; e1 <= '0; hold <= '0; cnt <= '0; hv <= 1'b0;
    end else begin
      e0 <= n_e0; e1 <= n_e1; hold <= n_hold; cnt <= n_cnt; hv <= n_hv;
    end
  end

  assign rx_data  = e0[DATA_W-1:0];
  assign rx_bit8  = e0[DATA_W];
  assign rx_ferr  = e0[FE];
  assign rx_perr  = e0[PE];
  assign rx_ovr   = e0[OV];
  assign rx_avail = cnt != 2'd0;
  assign rx_irq   = irq_en && gie && rx_avail;
endmodule

module uart_rx_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              rd_stb,
  input logic              gie,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_bit8,
  input logic              rx_ferr,
  input logic              rx_perr,
  input logic              rx_ovr,
  input logic              rx_avail,
  input logic              rx_irq,
  input logic              in_idle,
  input logic              hv,
  input logic [1:0]        cnt
);
  a_r2_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rx_avail && !rd_stb |=> rx_avail && $stable(rx_data) && $stable(rx_bit8)
                            && $stable(rx_ferr) && $stable(rx_perr) && $stable(rx_ovr));

  a_r2_flags_need_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ferr || rx_perr || rx_ovr || rx_bit8) |-> rx_avail);

  a_r3_ovr_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rd_stb));

  a_r11_hold_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    hv |-> cnt == 2'd2);

  a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> in_idle);

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_avail && gie);
endmodule

bind uart_rx_core uart_rx_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_stb(rd_stb), .gie(gie),
  .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
  .rx_ovr(rx_ovr), .rx_avail(rx_avail), .rx_irq(rx_irq),
  .in_idle(in_idle), .hv(hv), .cnt(cnt)
);

// File: tb/sim_uart_rx_core.sv
module sim_uart_rx_core;
  logic clk = 0, rst_n = 0, rxd = 1;
  logic rx_en = 1, par_en = 0, par_odd = 0, nine_bit = 0, dbl_speed = 0;
  logic mp_mode = 0, irq_en = 0, gie = 0, rd_stb = 0;
  logic [7:0] rx_data;
  logic rx_bit8, rx_ferr, rx_perr, rx_ovr, rx_avail, rx_irq;
  logic [1:0] tdiv = 0;
  logic baud_tick;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;
  always @(negedge clk) tdiv <= rst_n ? tdiv + 2'd1 : 2'd0;
  assign baud_tick = (tdiv == 2'd3);

  uart_rx_core u0 (.*);

  // fields: [13:5] data, [4] nine, [3] par_en, [2] par_odd, [1] corrupt parity, [0] stop level
  localparam logic [13:0] VEC [8] = '{
    {9'h0A5, 5'b00001}, {9'h03C, 5'b01001}, {9'h03C, 5'b01111}, {9'h1F0, 5'b11001},
    {9'h101, 5'b11110}, {9'h0FF, 5'b00010}, {9'h000, 5'b01011}, {9'h155, 5'b10001}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic tick_wait(input int n);
    for (int i = 0; i < n; ) begin
      @(posedge clk);
      if (baud_tick) i++;
    end
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int n);
    rxd = b;
    tick_wait(n);
  endtask

  task automatic send_frame(input logic [8:0] d, input logic badpar, input logic stopb);
    int r;
    logic p;
    r = dbl_speed ? 8 : 16;
    send_bit(1'b0, r);
    for (int i = 0; i < (nine_bit ? 9 : 8); i++) send_bit(d[i], r);
    if (par_en) begin
      p = (nine_bit ? ^d : ^d[7:0]) ^ par_odd ^ badpar;
      send_bit(p, r);
    end
    send_bit(stopb, r);
    send_bit(1'b1, 2 * r);
  endtask

  task automatic rd();
    rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 avail", rx_avail, 0);
    chk("R12 irq", rx_irq, 0);
    chk("R12 data", {rx_bit8, rx_data}, 0);
    chk("R12 flags", {rx_ferr, rx_perr, rx_ovr}, 0);

    foreach (VEC[k]) begin
      nine_bit = VEC[k][4]; par_en = VEC[k][3]; par_odd = VEC[k][2];
      send_frame(VEC[k][13:5], VEC[k][1], VEC[k][0]);
      chk("R2 avail", rx_avail, 1);
      chk("R10 data", rx_data, VEC[k][12:5]);
      chk("R8 bit8", rx_bit8, VEC[k][4] & VEC[k][13]);
      chk("R1 ferr", rx_ferr, !VEC[k][0]);
      chk("R4 perr", rx_perr, VEC[k][3] & VEC[k][1]);
      chk("R3 no ovr", rx_ovr, 0);
      rd();
      chk("R2 popped", rx_avail, 0);
    end
    nine_bit = 0; par_en = 0; par_odd = 0;

    rx_en = 0;
    send_frame(9'h0C3, 0, 1);
    chk("R9 disabled", rx_avail, 0);
    rx_en = 1;

    send_bit(1'b0, 3);
    send_bit(1'b1, 40);
    chk("R9 false start", rx_avail, 0);
    send_frame(9'h05A, 0, 1);
    chk("R9 after glitch", rx_data, 8'h5A);

    irq_en = 1; gie = 0; @(negedge clk);
    chk("R7 gie off", rx_irq, 0);
    gie = 1; @(negedge clk);
    chk("R7 both on", rx_irq, 1);
    irq_en = 0; @(negedge clk);
    chk("R7 en off", rx_irq, 0);
    irq_en = 1; rd();
    chk("R7 empty", rx_irq, 0);
    irq_en = 0; gie = 0;

    dbl_speed = 1;
    send_frame(9'h0C3, 0, 1);
    chk("R5 dbl data", rx_data, 8'hC3);
    chk("R5 dbl ferr", rx_ferr, 0);
    rd();
    dbl_speed = 0;

    mp_mode = 1; nine_bit = 1;
    send_frame(9'h055, 0, 1);
    chk("R6 data frame dropped", rx_avail, 0);
    send_frame(9'h1AA, 0, 1);
    chk("R6 addr kept", {rx_avail, rx_bit8, rx_data}, {2'b11, 8'hAA});
    rd();
    nine_bit = 0;
    send_frame(9'h07F, 0, 1);
    chk("R6 8bit dropped", rx_avail, 0);
    send_frame(9'h080, 0, 1);
    chk("R6 8bit kept", rx_data, 8'h80);
    rd();
    mp_mode = 0;

    send_frame(9'h011, 0, 1);
    send_frame(9'h022, 0, 0);
    chk("R2 head first", {rx_data, rx_ferr}, {8'h11, 1'b0});
    send_frame(9'h033, 0, 1);
    send_frame(9'h044, 0, 1);
    chk("R2 head kept", {rx_data, rx_ovr}, {8'h11, 1'b0});
    rd();
    chk("R2 second", {rx_data, rx_ferr, rx_ovr}, {8'h22, 2'b10});
    rd();
    chk("R11 waiting moved", {rx_avail, rx_data}, {1'b1, 8'h33});
    chk("R3 ovr marked", {rx_ovr, rx_ferr}, 2'b10);
    rd();
    chk("R3 new lost", rx_avail, 0);
    rd();
    chk("R2 empty read", {rx_avail, rx_data, rx_ovr}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule